// File: doc/BRIEF.md
# SMI Source Enable Register

This block is a 32-bit power-management control register. It decides which platform event sources may raise the system-management interrupt (SMI). Every enable bit is ANDed with a status input from the matching source. The results, a rerouted-NMI term and an I/O port-trap term are ORed into one registered SMI request. Software reaches the register through a simple read/write port at a fixed offset, with per-byte write enables.

The bits do not all behave alike. The GPIO-unlock enable can be set once and is cleared only by reset. The watchdog (TCO) enable ignores writes while an external lock input is high. A write-only bit does not store anything: writing a 1 to it emits a one-cycle pulse that sets an external global-status flop and requests an ACPI SCI. When the port-trap enable is set, any I/O access to one of the embedded-controller ports is claimed and not passed downstream, and it raises an SMI.

Top module: `smi_gate_ctrl`

## Requirements
- R1: Bit 27 (GPIO-unlock enable) is set by writing 1. Writing 0 does not clear it. Only `rst` returns it to 0.
- R2: Bits 18 (vendor USB2), 17 (legacy USB2), 14 (periodic) and 13 (TCO) are plain read/write enables, as is bit 27 once set. Each lets its status input assert `smi_req`, and a 0 in the bit blocks that input.
- R3: Writes to bit 13 are ignored in every cycle where `tco_lock` is 1.
- R4: `nmi_reroute` at 1 drives `smi_req` to 1 on the next cycle, whatever the value of bit 13.
- R5: While bit 11 is 1, an access with `io_valid` to port 0x62 or 0x66 gives `io_claim` = 1 and `smi_req` = 1 on the next cycle. Any other port, or bit 11 at 0, gives `io_claim` = 0.
- R6: Writing 1 to bit 7 pulses `gbl_sts_set` and `sci_req` high for exactly one cycle, starting the cycle after the write. Writing 0 to bit 7 gives no pulse. Bit 7 always reads 0.
- R7: Bits 31:28, 26:19, 16:15, 12, 10:8, 6:2 and 0 read as 0 and ignore writes. After an all-ones write with bit 27 set, the register reads 0x08066802.
- R8: After reset the register reads 0x00000002 when `CORP_DEFAULT` = 1 and 0x00000000 when it is 0. Bit 1 is a plain read/write bit.
- R9: `reg_be[k]` gates writes to bits 8k+7:8k. A lane whose enable is 0 keeps its contents.
- R10: A write updates the register only when `reg_addr` equals 0x30. `rd_data` holds the register value in the cycle after a read strobe at 0x30, and 0 otherwise.
- R11: `smi_req` is registered. It rises one cycle after an enabled condition appears and stays high for as long as the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high platform reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte write enables |
| rd_data | output | 32 | Registered read data |
| sts_periodic | input | 1 | Periodic timer status |
| sts_tco | input | 1 | Watchdog/TCO status |
| sts_usb_legacy | input | 1 | Legacy USB2 SMI status |
| sts_usb_vendor | input | 1 | Vendor-specific USB2 SMI status |
| sts_gpio_unlock | input | 1 | GPIO-unlock status |
| nmi_reroute | input | 1 | NMI rerouted to SMI |
| tco_lock | input | 1 | Blocks writes to bit 13 |
| io_valid | input | 1 | I/O access present this cycle |
| io_addr | input | 16 | I/O port address |
| io_claim | output | 1 | Access trapped: claim it and do not forward |
| smi_req | output | 1 | SMI request |
| gbl_sts_set | output | 1 | One-cycle global-status set pulse |
| sci_req | output | 1 | One-cycle SCI request |

## Verification
A wrong enable bit shows up in two places. `rd_data` exposes it one cycle after a read at 0x30. `smi_req` shows it one cycle after the matching status input rises, because that output either follows the status or ignores it. Faults in stickiness and locking show up only after a later write, so the bench reads the register back between writes. It also drives status inputs with enables at both 0 and 1, and drives the bypass and trap paths with the enables at 0.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
  localparam int REG_W      = 32;
  localparam int BE_W       = REG_W / 8;
  localparam int POS_GPIO   = 27;
  localparam int POS_USBV   = 18;
  localparam int POS_USBL   = 17;
  localparam int POS_PER    = 14;
  localparam int POS_TCO    = 13;
  localparam int POS_TRAP   = 11;
  localparam int POS_REL    = 7;
  localparam int POS_SPARE  = 1;
  // plain read/write bit positions (lock-gated and sticky bits handled apart)
  localparam int NUM_RW = 5;
  localparam int RW_POS [NUM_RW] = '{POS_USBV, POS_USBL, POS_PER, POS_TRAP, POS_SPARE};
  localparam int NUM_SRC = 5;

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_RW; i++) m[RW_POS[i]] = 1'b1;
    m[POS_TCO]  = 1'b1;
    m[POS_GPIO] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/smi_enable_regs.sv
module smi_enable_regs
  import smi_gate_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30,
  parameter logic        CORP_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [BE_W-1:0]   be,
  input  logic              tco_lock,
  output logic [REG_W-1:0]  en_q,
  output logic [REG_W-1:0]  rd_data,
  output logic              rel_pulse
);
  localparam logic [REG_W-1:0] MASK    = impl_mask();
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(CORP_DEFAULT) << POS_SPARE;

  logic             wr_hit, rd_hit;
  logic [REG_W-1:0] en_d;

  assign wr_hit = wr_en && (addr == REG_OFFSET);
  assign rd_hit = rd_en && (addr == REG_OFFSET);

  always_comb begin
    en_d = en_q;
    for (int i = 0; i < NUM_RW; i++)
      if (wr_hit && be[RW_POS[i]/8]) en_d[RW_POS[i]] = wdata[RW_POS[i]];
    if (wr_hit && be[POS_TCO/8] && !tco_lock) en_d[POS_TCO] = wdata[POS_TCO];
    if (wr_hit && be[POS_GPIO/8] && wdata[POS_GPIO]) en_d[POS_GPIO] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= RST_VAL;
      rd_data   <= '0;
      rel_pulse <= 1'b0;
    end else begin
      en_q      <= en_d & MASK;
      rd_data   <= rd_hit ? (en_q & MASK) : '0;
      rel_pulse <= wr_hit && be[POS_REL/8] && wdata[POS_REL];
    end
  end

  a_r1_gpio_sticky: assert property (@(posedge clk) disable iff (rst)
    en_q[POS_GPIO] |=> en_q[POS_GPIO]);
  a_r3_tco_locked: assert property (@(posedge clk) disable iff (rst)
    tco_lock |=> $stable(en_q[POS_TCO]));
  a_r6_rel_from_write: assert property (@(posedge clk) disable iff (rst)
    rel_pulse |-> $past(wr_hit && be[POS_REL/8] && wdata[POS_REL]));
  a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~MASK) == '0);
endmodule

// File: rtl/smi_port_trap.sv
module smi_port_trap #(
  parameter int IO_ADDR_W = 16,
  parameter int NUM_TRAPS = 2,
  parameter logic [NUM_TRAPS*IO_ADDR_W-1:0] TRAP_PORTS = {16'h0066, 16'h0062}
) (
  input  logic                 trap_en,
  input  logic                 io_valid,
  input  logic [IO_ADDR_W-1:0] io_addr,
  output logic                 hit
);
  logic [NUM_TRAPS-1:0] match;
  for (genvar g = 0; g < NUM_TRAPS; g++) begin : g_port
    assign match[g] = (io_addr == TRAP_PORTS[g*IO_ADDR_W +: IO_ADDR_W]);
  end
  assign hit = trap_en && io_valid && (|match);
endmodule

// File: rtl/smi_request_merge.sv
module smi_request_merge #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_sts,
  input  logic               nmi_reroute,
  input  logic               trap_hit,
  output logic               smi_req,
  output logic               io_claim
);
  logic smi_d;
  assign smi_d = (|(src_en & src_sts)) || nmi_reroute || trap_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_req  <= 1'b0;
      io_claim <= 1'b0;
    end else begin
      smi_req  <= smi_d;
      io_claim <= trap_hit;
    end
  end

  a_r4_nmi_bypass: assert property (@(posedge clk) disable iff (rst)
    nmi_reroute |=> smi_req);
  a_r5_claim_raises_smi: assert property (@(posedge clk) disable iff (rst)
    io_claim |-> smi_req);
  a_r11_smi_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_req) |-> $past(|(src_en & src_sts) || nmi_reroute || trap_hit));
endmodule

// File: rtl/smi_gate_ctrl.sv
module smi_gate_ctrl
  import smi_gate_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET   = 8'h30,
  parameter logic              CORP_DEFAULT = 1'b0,
  parameter int                IO_ADDR_W    = 16,
  parameter int                NUM_TRAPS    = 2,
  parameter logic [NUM_TRAPS*IO_ADDR_W-1:0] TRAP_PORTS = {16'h0066, 16'h0062}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic [3:0]           reg_be,
  output logic [31:0]          rd_data,
  input  logic                 sts_periodic,
  input  logic                 sts_tco,
  input  logic                 sts_usb_legacy,
  input  logic                 sts_usb_vendor,
  input  logic                 sts_gpio_unlock,
  input  logic                 nmi_reroute,
  input  logic                 tco_lock,
  input  logic                 io_valid,
  input  logic [IO_ADDR_W-1:0] io_addr,
  output logic                 io_claim,
  output logic                 smi_req,
  output logic                 gbl_sts_set,
  output logic                 sci_req
);
  logic [REG_W-1:0]   en_q;
  logic               rel_pulse, trap_hit;
  logic [NUM_SRC-1:0] src_en, src_sts;

  smi_enable_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .CORP_DEFAULT(CORP_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .be(reg_be), .tco_lock(tco_lock),
    .en_q(en_q), .rd_data(rd_data), .rel_pulse(rel_pulse));

  smi_port_trap #(.IO_ADDR_W(IO_ADDR_W), .NUM_TRAPS(NUM_TRAPS), .TRAP_PORTS(TRAP_PORTS)) u_trap (
    .trap_en(en_q[POS_TRAP]), .io_valid(io_valid), .io_addr(io_addr), .hit(trap_hit));

  assign src_en  = {en_q[POS_GPIO], en_q[POS_USBV], en_q[POS_USBL], en_q[POS_PER], en_q[POS_TCO]};
  assign src_sts = {sts_gpio_unlock, sts_usb_vendor, sts_usb_legacy, sts_periodic, sts_tco};

  smi_request_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .clk(clk), .rst(rst), .src_en(src_en), .src_sts(src_sts),
    .nmi_reroute(nmi_reroute), .trap_hit(trap_hit),
    .smi_req(smi_req), .io_claim(io_claim));

  assign gbl_sts_set = rel_pulse;
  assign sci_req     = rel_pulse;
endmodule

// File: tb/smi_gate_ctrl_bench.sv
module smi_gate_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 8'h30;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] rd_data;
  logic sts_periodic = 0, sts_tco = 0, sts_usb_legacy = 0, sts_usb_vendor = 0, sts_gpio_unlock = 0;
  logic nmi_reroute = 0, tco_lock = 0, io_valid = 0;
  logic [15:0] io_addr = '0;
  logic io_claim, smi_req, gbl_sts_set, sci_req;
  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smi_gate_ctrl u_smi_gate_ctrl (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read result is due
  always @(posedge clk) rd_seen <= reg_rd && reg_addr == 8'h30;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) check("R10 unexpected read", 1, 0);
    else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1;
    step();
    reg_wr = 0; reg_addr = 8'h30;
  endtask

  task automatic rd(string tag, logic [31:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_addr = 8'h30; reg_rd = 1;
    step();
    reg_rd = 0;
    step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0; step();
    check("R8 reset smi", smi_req, 0);
    check("R8 reset gbl", gbl_sts_set, 0);
    rd("R8 reset value", 32'h0);
    check("R10 idle rd_data zero", rd_data, 0);

    // all ones write
    reg_addr = 8'h30; reg_wdata = 32'hFFFF_FFFF; reg_be = 4'hF; reg_wr = 1;
    step(); reg_wr = 0;
    check("R6 gbl pulse", gbl_sts_set, 1);
    check("R6 sci pulse", sci_req, 1);
    step();
    check("R6 pulse one cycle", {gbl_sts_set, sci_req}, 0);
    rd("R7 implemented mask, R6 bit7 reads 0", 32'h0806_6802);

    wr(8'h30, 32'h0, 4'hF);
    check("R6 write 0 no pulse", gbl_sts_set, 0);
    rd("R1 bit27 sticky", 32'h0800_0000);

    wr(8'h34, 32'hFFFF_FFFF, 4'hF);
    rd("R10 other address ignored", 32'h0800_0000);

    wr(8'h30, 32'hFFFF_FFFF, 4'b0010);
    rd("R9 byte lane 1 only", 32'h0800_6800);
    wr(8'h30, 32'h0, 4'b1101);
    rd("R9 lane 1 kept", 32'h0800_6800);

    tco_lock = 1;
    wr(8'h30, 32'h0, 4'hF);
    rd("R3 tco held while locked", 32'h0800_2000);
    tco_lock = 0;
    wr(8'h30, 32'h0, 4'hF);
    rd("R3 tco clears unlocked", 32'h0800_0000);

    // source gating
    sts_periodic = 1; step();
    check("R2 periodic blocked", smi_req, 0);
    wr(8'h30, 32'h0000_4000, 4'hF);
    step();
    check("R11 periodic enabled smi", smi_req, 1);
    step();
    check("R11 smi held", smi_req, 1);
    sts_periodic = 0; step();
    check("R11 smi drops", smi_req, 0);
    sts_gpio_unlock = 1; step();
    check("R2 gpio enabled smi", smi_req, 1);
    sts_gpio_unlock = 0;
    sts_usb_legacy = 1; step();
    check("R2 usb legacy blocked", smi_req, 0);
    sts_usb_legacy = 0;

    // NMI bypass, TCO enable 0
    sts_tco = 1; step();
    check("R2 tco blocked", smi_req, 0);
    nmi_reroute = 1; step();
    check("R4 nmi bypass", smi_req, 1);
    nmi_reroute = 0; sts_tco = 0; step();
    check("R4 nmi removed", smi_req, 0);

    // port trap
    io_valid = 1; io_addr = 16'h0062; step();
    check("R5 trap disabled", {io_claim, smi_req}, 0);
    io_valid = 0;
    wr(8'h30, 32'h0000_0800, 4'hF);
    io_valid = 1; io_addr = 16'h0066; step();
    check("R5 trap 66h", {io_claim, smi_req}, 2'b11);
    io_addr = 16'h0062; step();
    check("R5 trap 62h", {io_claim, smi_req}, 2'b11);
    io_addr = 16'h0064; step();
    check("R5 no trap 64h", {io_claim, smi_req}, 0);
    io_valid = 0;

    // reset clears sticky bit
    rst = 1; step(); rst = 0; step();
    rd("R1 reset clears bit27", 32'h0);
    wr(8'h30, 32'h0000_0002, 4'h1);
    rd("R8 bit1 read/write", 32'h0000_0002);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule